// File: doc/BRIEF.md
# Bank-Windowed Register File

This block is the general register file of a 16-bit processor core. The programmer sees sixteen registers, numbered 0 to 15. Registers 0 to 7 are windowed into a larger backing store, and the upper byte of the status register selects which window is active. Registers 8 to 15 form one fixed set that every window shares. Register 14 holds the status word. Any read of it shows bit 0 as 1, whatever was stored there.

The core reads operands through two combinational read ports and writes results through one synchronous write port. The flag logic has its own update path. That path replaces only the five condition flags of the status word and leaves the bank selector, the two spare bits and bit 0 alone. Because the bank selector is ordinary status-register content, software switches windows by writing register 14. The new window applies from the next cycle on.

Top module: `bank_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register in every window and the fixed set. After reset, bank 0 is active, every read returns 0x0000 and a read of register 14 returns 0x0001.
- R2: A read of register 14, on either read port or on `sr_out`, always returns bit 0 as 1, even after a write that stored 0 in bit 0. The other fifteen bits read back exactly as stored.
- R3: Registers 0 to 7 are banked. The physical entry is chosen by the register number together with status bits 15:8. A value written in one bank is not visible in another bank, and it is visible again when that bank is reselected.
- R4: Registers 8 to 15 are not banked. A value written while one bank is active reads back unchanged under any other bank.
- R5: A write to register 14 that changes bits 15:8 takes effect for reads from the next clock edge. In the cycle of that write, reads of registers 0 to 7 still come from the previous bank.
- R6: When `flag_we` is high, the next edge loads `flag_in` into status bits 5:1, with `flag_in[0]`→bit 1 (X), `[1]`→bit 2 (C), `[2]`→bit 3 (Z), `[3]`→bit 4 (N) and `[4]`→bit 5 (V). Bits 15:6 and bit 0 are kept.
- R7: If `flag_we` and a general write to register 14 happen in the same cycle, the flag update wins. The general write data is discarded, and the result is the old status word with new flags.
- R8: A read of a register that is being written in the same cycle returns the old value. The new value is read after the clock edge.
- R9: The two read ports are independent and can read different registers, in banked and fixed ranges, in the same cycle.
- R10: With `wr_en` and `flag_we` low, no register changes, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 4 | Register number for read port A |
| rd_a_data | output | 16 | Combinational read data, port A |
| rd_b_addr | input | 4 | Register number for read port B |
| rd_b_data | output | 16 | Combinational read data, port B |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | 16 | Data to write |
| flag_we | input | 1 | Flag update enable |
| flag_in | input | 5 | New flags {V,N,Z,C,X} |
| sr_out | output | 16 | Current status word, bit 0 reads as 1 |

## Verification
A wrong bank selector shows at the ports one cycle after the status write that caused it. Reads of registers 0 to 7 then return data from a foreign window, while registers 8 to 15 still read correctly. That split is what tells a mapping fault apart from a storage fault. A flag merge that clobbers the upper byte is visible on `sr_out` right after the update edge. It also moves every banked read to another window from that edge on. A write that lands in the wrong place stays hidden until the victim register is read back, so the directed sequences read each written register under both the writing bank and a different one.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int SLOT_W  = 3;                 // registers per window = 2**SLOT_W
    localparam int BANK_W  = 8;                 // width of the bank selector
    localparam int NFIXED  = 1 << SLOT_W;
    localparam int FLAG_W  = 5;
    localparam logic [ADDR_W-1:0] SR_NUM  = 4'd14;
    localparam logic [SLOT_W-1:0] SR_SLOT = SR_NUM[SLOT_W-1:0];

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
        logic x;
    } flags_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [1:0]        spare;
        flags_t            flags;
        logic              one;
    } status_t;

    function automatic logic is_banked(input logic [ADDR_W-1:0] r);
        return ~r[ADDR_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] sr_view(input logic [DATA_W-1:0] raw);
        return raw | {{(DATA_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/rf_bank_store.sv
module rf_bank_store
    import regfile_pkg::*;
#(
    parameter int BW = BANK_W,
    parameter int SW = SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     bank,
    input  logic              we,
    input  logic [SW-1:0]     w_slot,
    input  logic [DATA_W-1:0] w_data,
    input  logic [SW-1:0]     ra_slot,
    input  logic [SW-1:0]     rb_slot,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);
    localparam int IDX_W = BW + SW;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[{bank, w_slot}] <= w_data;
        end
    end

    assign ra_data = mem[{bank, ra_slot}];
    assign rb_data = mem[{bank, rb_slot}];

endmodule

// File: rtl/rf_fixed_regs.sv
module rf_fixed_regs
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] w_slot,
    input  logic [DATA_W-1:0] w_data,
    input  logic              flag_we,
    input  flags_t            flag_in,
    input  logic [SLOT_W-1:0] ra_slot,
    input  logic [SLOT_W-1:0] rb_slot,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output status_t           sr_q
);
    logic [NFIXED-1:0][DATA_W-1:0] regs;
    status_t sr_cur;
    logic    run_q;

    assign sr_cur = status_t'(regs[SR_SLOT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (we) regs[w_slot] <= w_data;
            if (flag_we) regs[SR_SLOT] <= {sr_cur.bank, sr_cur.spare, flag_in, sr_cur.one};
        end
    end

    assign ra_data = regs[ra_slot];
    assign rb_data = regs[rb_slot];
    assign sr_q    = sr_cur;

    // R6
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && flag_we |=> sr_q.flags == $past(flag_in));

    // R6
    flag_keep_upper_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && flag_we |=> (sr_q.bank == $past(sr_q.bank)) && (sr_q.spare == $past(sr_q.spare)));

    // R7
    flag_wins_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && flag_we && we && (w_slot == SR_SLOT) |=> sr_q.bank == $past(sr_q.bank));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && !we && !flag_we |=> $stable(regs));

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import regfile_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  rd_a_addr,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [ADDR_W-1:0]  rd_b_addr,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               flag_we,
    input  logic [FLAG_W-1:0]  flag_in,
    output logic [DATA_W-1:0]  sr_out
);
    status_t           sr_q;
    logic [DATA_W-1:0] bk_a, bk_b, fx_a, fx_b;
    logic              wr_bank, wr_fixed;

    assign wr_bank  = wr_en &  is_banked(wr_addr);
    assign wr_fixed = wr_en & ~is_banked(wr_addr);

    rf_bank_store #(.BW(BANK_W), .SW(SLOT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .bank    (sr_q.bank),
        .we      (wr_bank),
        .w_slot  (wr_addr[SLOT_W-1:0]),
        .w_data  (wr_data),
        .ra_slot (rd_a_addr[SLOT_W-1:0]),
        .rb_slot (rd_b_addr[SLOT_W-1:0]),
        .ra_data (bk_a),
        .rb_data (bk_b)
    );

    rf_fixed_regs u_fixed (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_fixed),
        .w_slot  (wr_addr[SLOT_W-1:0]),
        .w_data  (wr_data),
        .flag_we (flag_we),
        .flag_in (flags_t'(flag_in)),
        .ra_slot (rd_a_addr[SLOT_W-1:0]),
        .rb_slot (rd_b_addr[SLOT_W-1:0]),
        .ra_data (fx_a),
        .rb_data (fx_b),
        .sr_q    (sr_q)
    );

    always_comb begin
        rd_a_data = is_banked(rd_a_addr) ? bk_a : fx_a;
        rd_b_data = is_banked(rd_b_addr) ? bk_b : fx_b;
        if (rd_a_addr == SR_NUM) rd_a_data = sr_view(rd_a_data);
        if (rd_b_addr == SR_NUM) rd_b_data = sr_view(rd_b_data);
    end

    assign sr_out = sr_view(sr_q);

    // R2
    sr_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        sr_out[0] && ((rd_a_addr != SR_NUM) || rd_a_data[0]));

    // R2
    sr_ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == SR_NUM) |-> rd_b_data == sr_out);

endmodule

// File: tb/tb_bank_regfile.sv
module tb_bank_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [15:0] rd_a_data, rd_b_data, wr_data, sr_out;
    logic        wr_en, flag_we;
    logic [4:0]  flag_in;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bank_regfile dut (
        .clk(clk), .rst(rst),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_we(flag_we), .flag_in(flag_in), .sr_out(sr_out)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_a(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_a_addr = a;
        #1 d = rd_a_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int i = 0; i < 16; i++) begin
            rd_a(4'(i), d);
            chk($sformatf("R1 reg%0d after reset", i), d, (i == 14) ? 16'h0001 : 16'h0000);
        end
        chk("R1 sr_out after reset", sr_out, 16'h0001);
    endtask

    task automatic t_sr_lsb();
        logic [15:0] d;
        wr(4'd14, 16'h0000);
        rd_a(4'd14, d);
        chk("R2 sr lsb forced (wrote 0000)", d, 16'h0001);
        wr(4'd14, 16'h00FE);
        rd_a(4'd14, d);
        chk("R2 sr other bits kept", d, 16'h00FF);
        chk("R2 sr_out lsb", sr_out, 16'h00FF);
        wr(4'd14, 16'h0000);
    endtask

    task automatic t_banks();
        logic [15:0] d;
        wr(4'd3, 16'h1111);
        wr(4'd14, 16'h0500);
        rd_a(4'd3, d);
        chk("R3 new bank starts empty", d, 16'h0000);
        wr(4'd3, 16'h5555);
        wr(4'd9, 16'hABCD);
        rd_a(4'd3, d);
        chk("R3 bank5 value", d, 16'h5555);
        wr(4'd14, 16'h0000);
        rd_a(4'd3, d);
        chk("R3 bank0 value restored", d, 16'h1111);
        rd_a(4'd9, d);
        chk("R4 fixed reg shared across banks", d, 16'hABCD);
    endtask

    task automatic t_bank_switch_timing();
        @(negedge clk);
        rd_a_addr = 4'd3;
        wr_en = 1'b1; wr_addr = 4'd14; wr_data = 16'h0500;
        #1 chk("R5 old bank during SR write", rd_a_data, 16'h1111);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R5 new bank after edge", rd_a_data, 16'h5555);
    endtask

    task automatic t_flags();
        wr(4'd14, 16'hA5C1);
        @(negedge clk);
        flag_we = 1'b1; flag_in = 5'b10110;
        @(negedge clk);
        flag_we = 1'b0;
        #1 chk("R6 flag merge", sr_out, 16'hA5ED);
        @(negedge clk);
        flag_we = 1'b1; flag_in = 5'b00000;
        @(negedge clk);
        flag_we = 1'b0;
        #1 chk("R6 flags cleared, upper kept", sr_out, 16'hA5C1);
    endtask

    task automatic t_prio();
        logic [15:0] d;
        @(negedge clk);
        flag_we = 1'b1; flag_in = 5'b11111;
        wr_en = 1'b1; wr_addr = 4'd14; wr_data = 16'h1234;
        @(negedge clk);
        flag_we = 1'b0; wr_en = 1'b0;
        rd_a(4'd14, d);
        chk("R7 flag update beats write", d, 16'hA5FF);
        wr(4'd14, 16'h0000);
    endtask

    task automatic t_rdw();
        @(negedge clk);
        rd_a_addr = 4'd9;
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h7777;
        #1 chk("R8 old value in write cycle", rd_a_data, 16'hABCD);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R8 new value after edge", rd_a_data, 16'h7777);
    endtask

    task automatic t_ports();
        @(negedge clk);
        rd_a_addr = 4'd9; rd_b_addr = 4'd3;
        #1;
        chk("R9 port A fixed", rd_a_data, 16'h7777);
        chk("R9 port B banked", rd_b_data, 16'h1111);
        rd_b_addr = 4'd14;
        #1 chk("R9 port B status", rd_b_data, 16'h0001);
    endtask

    task automatic t_noen();
        logic [15:0] d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 4'd9; wr_data = 16'hDEAD;
        @(negedge clk);
        wr_addr = 4'd3; wr_data = 16'hBEEF;
        @(negedge clk);
        rd_a(4'd9, d);
        chk("R10 fixed reg untouched", d, 16'h7777);
        rd_a(4'd3, d);
        chk("R10 banked reg untouched", d, 16'h1111);
    endtask

    task automatic t_reset_clears();
        logic [15:0] d;
        do_reset();
        rd_a(4'd14, d);
        chk("R1 bank 0 after reset", d, 16'h0001);
        wr(4'd14, 16'h0500);
        rd_a(4'd3, d);
        chk("R1 bank5 cleared by reset", d, 16'h0000);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; flag_we = 1'b0; flag_in = '0;
        wr_addr = '0; wr_data = '0; rd_a_addr = '0; rd_b_addr = '0;
        do_reset();
        t_reset();
        t_sr_lsb();
        t_banks();
        t_bank_switch_timing();
        wr(4'd14, 16'h0000);
        t_flags();
        t_prio();
        t_rdw();
        t_ports();
        t_noen();
        t_reset_clears();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule